// File: doc/BRIEF.md
# CPU Interrupt Pending and Mask Unit

This block is the interrupt front end of a CPU core. It gathers eight interrupt lines, holds a per-line enable mask and a global enable in a status word, and holds the pending field in a cause word. Two of the lines are software interrupts: the CPU raises and lowers them by writing the cause word. The other six are level-sensitive external requests. They pass through a two-flop synchronizer, and the highest of them is shared with an internal timer request. Their pending bits mirror the synchronized level and cannot be cleared by the CPU.

A line is active when its pending bit and its enable bit are both set. The unit always presents the index of the highest-numbered active line, a flag that some line is active, and a request to the core that is gated by the global enable. When the core asks for a dispatch while no line is active, the unit raises a one-cycle spurious flag.

Top module: `cpu_irq_unit`

## Requirements
- R1: There are exactly eight lines, numbered 0 to 7, and `irq_id_o` is a 3-bit line number.
- R2: Lines 0 and 1 are software lines. A write with `reg_sel`=1 (cause word) loads their pending bits from `reg_wdata[8]` and `reg_wdata[9]`. No other event changes them.
- R3: For n in 2..7, the pending bit of line n equals `ext_irq_in[n-2]` as sampled two rising clock edges earlier, and a cause write cannot change it.
- R4: The level that feeds line 7 is `ext_irq_in[5]` OR `timer_irq_in`.
- R5: The status word (`reg_sel`=0) holds the enable for line n at bit 8+n and a global enable at bit 0. A status write loads exactly these nine bits, and every other status bit reads 0.
- R6: `irq_valid_o` is 1 exactly when at least one line has both its pending bit and its enable bit set.
- R7: `spurious_o` is 1 for the single cycle after a rising edge at which `dispatch_req` was 1 while no line was active, and 0 otherwise.
- R8: When lines are active, `irq_id_o` gives the highest-numbered active line. When none is active it reads 0.
- R9: A rising edge with `rst_n` low clears every enable bit, the global enable, both software pending bits and the synchronizer state.
- R10: `irq_req_o` equals `irq_valid_o` AND the global enable bit.
- R11: `reg_rdata` returns the word picked by `reg_sel`. The cause word carries pending bit n at bit 8+n and reads 0 everywhere else. Cause write data outside bits 8 and 9 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Write strobe for the selected word |
| reg_sel | input | 1 | Word select: 0 status, 1 cause |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| ext_irq_in | input | 6 | Asynchronous levels for lines 2 to 7 |
| timer_irq_in | input | 1 | Internal timer request, merged into line 7 |
| dispatch_req | input | 1 | Core asks which line to service |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_valid_o | output | 1 | Some line is active |
| irq_id_o | output | 3 | Highest active line number |
| spurious_o | output | 1 | Dispatch found no active line |

## Verification
On every cycle the assertions check that the reported line is active and that no higher line is active. They also check that the request never rises while the global enable is clear, that the software pending bits stay unchanged unless the cause word is written, that a dispatch with nothing active raises the spurious flag, and that reset clears the mask state. Only the bench scenarios can show the two-edge latency of the external levels, the merging of the timer into line 7, and the fact that a cause write cannot drop an external pending bit. The same holds for the exact read-back layout of both words under random mask, pending and input patterns.

// File: rtl/irq_pkg.sv
// Package: shared constants and types of the CPU interrupt unit.
// Assumes a fixed layout: pending and enable fields start at bit 8 of their words.
package irq_pkg;
    localparam int IRQ_LINES  = 8;
    localparam int SW_LINES   = 2;
    localparam int FIELD_LSB  = 8;
    localparam int GIE_BIT    = 0;
    localparam int WORD_W     = 32;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CAUSE  = 1'b1
    } word_sel_e;
endpackage

// File: rtl/irq_sync.sv
// Module: multi-stage level synchronizer, one chain per bit.
// Assumes the inputs are levels that stay put for longer than STAGES clocks.
module irq_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Move the level one stage further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
// Module: status and cause words of the interrupt unit.
// Holds the enable mask, the global enable and the software pending bits.
// Assumes the hardware levels arrive already synchronized.
module irq_regs
    import irq_pkg::*;
#(
    parameter int LINES  = IRQ_LINES,
    parameter int SWL    = SW_LINES,
    parameter int DATA_W = WORD_W,
    parameter int LSB    = FIELD_LSB
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   sel,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [LINES-SWL-1:0]   hw_level,
    output logic [LINES-1:0]       line_en,
    output logic                   gie,
    output logic [LINES-1:0]       line_pend,
    output logic [DATA_W-1:0]      rdata
);
    logic [LINES-1:0]  en_q;
    logic              gie_q;
    logic [SWL-1:0]    sw_q;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] cause_word;

    // Load the mask and global enable on a status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            gie_q <= 1'b0;
        end else if (wr_en && sel == SEL_STATUS) begin
            en_q  <= wdata[LSB +: LINES];
            gie_q <= wdata[GIE_BIT];
        end
    end

    // Load the software pending bits on a cause write.
    always_ff @(posedge clk) begin
        if (!rst_n)                           sw_q <= '0;
        else if (wr_en && sel == SEL_CAUSE)   sw_q <= wdata[LSB +: SWL];
    end

    assign line_pend = {hw_level, sw_q};
    assign line_en   = en_q;
    assign gie       = gie_q;

    // Assemble both words with zeros in the undefined positions.
    always_comb begin
        status_word = '0;
        status_word[LSB +: LINES] = en_q;
        status_word[GIE_BIT]      = gie_q;
        cause_word = '0;
        cause_word[LSB +: LINES]  = line_pend;
    end

    // Return the selected word.
    assign rdata = (sel == SEL_CAUSE) ? cause_word : status_word;
endmodule

// File: rtl/irq_prio.sv
// Module: priority encoder that picks the highest set bit.
// Assumes index 0 is reported when nothing is set.
module irq_prio #(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] active,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan upward so that the last hit, the highest line, wins.
    always_comb begin
        idx = '0;
        for (int i = 0; i < LINES; i++) begin
            if (active[i]) idx = IDX_W'(i);
        end
    end

    assign any = |active;
endmodule

// File: rtl/cpu_irq_unit.sv
// Module: CPU interrupt pending and mask unit (top).
// Merges the timer into the highest external line, synchronizes the external
// levels, masks the pending field, and reports the highest active line.
// Assumes a single core and a synchronous active-low reset.
module cpu_irq_unit
    import irq_pkg::*;
#(
    parameter int HAS_TIMER   = 1,
    parameter int SYNC_STAGES = 2,
    localparam int HW_LINES   = IRQ_LINES - SW_LINES,
    localparam int IDX_W      = $clog2(IRQ_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic                 reg_sel,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic [HW_LINES-1:0]  ext_irq_in,
    input  logic                 timer_irq_in,
    input  logic                 dispatch_req,
    output logic                 irq_req_o,
    output logic                 irq_valid_o,
    output logic [IDX_W-1:0]     irq_id_o,
    output logic                 spurious_o
);
    localparam logic TIMER_GATE = (HAS_TIMER != 0);

    logic [HW_LINES-1:0]  hw_raw;
    logic [HW_LINES-1:0]  hw_sync;
    logic [IRQ_LINES-1:0] line_en;
    logic [IRQ_LINES-1:0] line_pend;
    logic [IRQ_LINES-1:0] line_act;
    logic                 gie;
    logic                 spur_q;

    // Merge the timer request into the top external line.
    assign hw_raw = ext_irq_in
                  | (HW_LINES'(timer_irq_in & TIMER_GATE) << (HW_LINES - 1));

    irq_sync #(.WIDTH(HW_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (hw_raw),
        .sync_out (hw_sync)
    );

    irq_regs #(.LINES(IRQ_LINES), .SWL(SW_LINES), .DATA_W(WORD_W), .LSB(FIELD_LSB)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .hw_level  (hw_sync),
        .line_en   (line_en),
        .gie       (gie),
        .line_pend (line_pend),
        .rdata     (reg_rdata)
    );

    assign line_act = line_pend & line_en;

    irq_prio #(.LINES(IRQ_LINES)) u_prio (
        .active (line_act),
        .idx    (irq_id_o),
        .any    (irq_valid_o)
    );

    // Flag a dispatch that finds no active line.
    always_ff @(posedge clk) begin
        if (!rst_n) spur_q <= 1'b0;
        else        spur_q <= dispatch_req && !irq_valid_o;
    end

    assign spurious_o = spur_q;
    assign irq_req_o  = irq_valid_o & gie;
endmodule

// File: rtl/cpu_irq_unit_chk.sv
// Module: assertion checker bound to the interrupt unit.
module cpu_irq_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_en,
    input logic       reg_sel,
    input logic       dispatch_req,
    input logic [7:0] line_en,
    input logic [7:0] line_pend,
    input logic       gie,
    input logic       irq_req_o,
    input logic       irq_valid_o,
    input logic [2:0] irq_id_o,
    input logic       spurious_o
);
    logic [7:0] act_c;
    assign act_c = line_en & line_pend;

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (line_en == 8'h00 && !gie && line_pend[1:0] == 2'b00));

    assert_req_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_req_o);

    assert_valid_means_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o == (act_c != 8'h00));

    assert_id_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (act_c[irq_id_o] && ((act_c >> irq_id_o) >> 1) == 8'h00));

    assert_sw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_sel) |=> $stable(line_pend[1:0]));

    assert_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch_req && act_c == 8'h00) |=> spurious_o);

    assert_no_false_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dispatch_req |=> !spurious_o);
endmodule

bind cpu_irq_unit cpu_irq_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_sel      (reg_sel),
    .dispatch_req (dispatch_req),
    .line_en      (line_en),
    .line_pend    (line_pend),
    .gie          (gie),
    .irq_req_o    (irq_req_o),
    .irq_valid_o  (irq_valid_o),
    .irq_id_o     (irq_id_o),
    .spurious_o   (spurious_o)
);

// File: tb/cpu_irq_unit_test.sv
module cpu_irq_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROUNDS     = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  ext_irq_in = '0;
    logic        timer_irq_in = 1'b0;
    logic        dispatch_req = 1'b0;
    logic        irq_req_o, irq_valid_o, spurious_o;
    logic [2:0]  irq_id_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model of the architectural state.
    logic [7:0] m_en;
    logic       m_gie;
    logic [1:0] m_sw;
    logic [5:0] m_hw;

    cpu_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_irq_in(ext_irq_in),
        .timer_irq_in(timer_irq_in), .dispatch_req(dispatch_req),
        .irq_req_o(irq_req_o), .irq_valid_o(irq_valid_o), .irq_id_o(irq_id_o),
        .spurious_o(spurious_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] f_act();
        return {m_hw, m_sw} & m_en;
    endfunction

    function automatic logic [2:0] f_id(input logic [7:0] a);
        logic [2:0] r = 3'd0;
        for (int i = 0; i < 8; i++) if (a[i]) r = 3'(i);
        return r;
    endfunction

    function automatic logic [31:0] f_status();
        return {16'h0, m_en, 7'h0, m_gie};
    endfunction

    function automatic logic [31:0] f_cause();
        return {16'h0, m_hw, m_sw, 8'h0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (sel) m_sw = d[9:8];
        else begin m_en = d[15:8]; m_gie = d[0]; end
    endtask

    task automatic read_word(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_outputs(input string tag);
        logic [31:0] d;
        logic [7:0] a;
        a = f_act();
        read_word(1'b0, d); chk({tag, " R5 status"}, d, f_status());
        read_word(1'b1, d); chk({tag, " R11 cause"}, d, f_cause());
        chk({tag, " R6 valid"}, 32'(irq_valid_o), 32'(a != 0));
        chk({tag, " R8 id"}, 32'(irq_id_o), 32'(f_id(a)));
        chk({tag, " R10 req"}, 32'(irq_req_o), 32'((a != 0) && m_gie));
    endtask

    task automatic do_dispatch(input string tag);
        logic exp_s;
        exp_s = (f_act() == 0);
        dispatch_req = 1'b1;
        @(negedge clk);
        dispatch_req = 1'b0;
        chk({tag, " R7 spurious"}, 32'(spurious_o), 32'(exp_s));
        @(negedge clk);
        chk({tag, " R7 pulse end"}, 32'(spurious_o), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] r;
        void'($urandom(32'd1234));
        m_en = '0; m_gie = 1'b0; m_sw = '0; m_hw = '0;

        // R9: reset clears state even if writes are attempted during reset.
        ext_irq_in = 6'h3f;
        reg_sel = 1'b1; reg_wdata = 32'hffff_ffff; reg_wr_en = 1'b1;
        repeat (3) @(negedge clk);
        reg_wr_en = 1'b0;
        ext_irq_in = 6'h00;
        read_word(1'b0, d); chk("R9 status after reset", d, 32'h0);
        read_word(1'b1, d); chk("R9 cause after reset", d, 32'h0);
        chk("R9 req after reset", 32'(irq_req_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 sync cleared", 32'(irq_valid_o), 32'd0);

        // R5: status layout, undefined bits read zero.
        write_word(1'b0, 32'hffff_ffff);
        read_word(1'b0, d); chk("R5 status ones", d, 32'h0000_ff01);
        do_dispatch("R7 idle");

        // R3: two-edge latency of line 2.
        ext_irq_in = 6'h01;
        @(negedge clk);
        read_word(1'b1, d); chk("R3 one edge not yet", d, 32'h0);
        @(negedge clk);
        m_hw = 6'h01;
        read_word(1'b1, d); chk("R3 two edges", d, 32'h0000_0400);
        chk("R8 line 2", 32'(irq_id_o), 32'd2);

        // R11 / R3: cause write cannot clear hardware bit and ignores other bits.
        write_word(1'b1, 32'hffff_fcff);
        read_word(1'b1, d); chk("R11 cause masked write", d, 32'h0000_0400);
        write_word(1'b1, 32'h0000_0300);
        read_word(1'b1, d); chk("R2 sw set", d, 32'h0000_0700);
        chk("R8 sw below hw", 32'(irq_id_o), 32'd2);

        // R4: timer alone raises line 7.
        ext_irq_in = 6'h00; timer_irq_in = 1'b1;
        @(negedge clk); @(negedge clk);
        m_hw = 6'h20;
        read_word(1'b1, d); chk("R4 timer to line 7", d, 32'h0000_8300);
        chk("R8 line 7 wins", 32'(irq_id_o), 32'd7);
        timer_irq_in = 1'b0;
        @(negedge clk); @(negedge clk);
        m_hw = 6'h00;

        // R10: global enable off masks the request only.
        write_word(1'b0, 32'h0000_0100);
        check_outputs("R10 gie off");
        write_word(1'b1, 32'h0);
        check_outputs("R2 sw clear");
        do_dispatch("R7 none active");

        // R1: random rounds over all lines.
        for (int k = 0; k < ROUNDS; k++) begin
            @(negedge clk);
            r = $urandom;
            ext_irq_in = r[5:0];
            timer_irq_in = r[6] & r[7];
            write_word(1'b0, $urandom);
            write_word(1'b1, $urandom);
            @(negedge clk);
            m_hw = ext_irq_in | {timer_irq_in, 5'b0};
            check_outputs("R1 random");
            do_dispatch("R7 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule